// File: doc/BRIEF.md
# Stream-to-Memory One-Shot Write Engine

This block takes 32-bit beats from a ready/valid stream input that carries an end-of-packet marker and writes them to consecutive word addresses through a simple valid/ready memory write port. Software sets a destination byte address and then writes a byte length, which arms one transfer. The transfer ends on the first written beat that carries the end-of-packet marker, or on the beat that uses up the programmed length, whichever comes first. The engine then raises a done flag and does nothing more until software arms it again.

A four-entry skid buffer sits in front of the memory port and accepts stream beats whether or not a transfer is active. Stream-side ready drops only when that buffer is full. Beats that arrive after a transfer completes are kept and are written, in arrival order, once the next transfer is armed. Status outputs show busy, done, whether the length ran out before the packet ended, and the number of bytes written by the last transfer.

Top module: `s2m_oneshot_writer`

## Requirements
- R1: After reset busy, done, lenExhausted and mValid are 0, bytesDone is 0 and sReady is 1.
- R2: A config write with cfgSel=0 while idle sets the destination address. A config write with cfgSel=1 and a nonzero length while idle arms a transfer, and busy is 1 from the next cycle. The k-th beat written (k from 0) goes out with mAddr = destination + 4*k and mData equal to that beat's stream data, in stream order.
- R3: When a written beat has sLast=1, the transfer ends even if the programmed length is larger: busy is 0 and done is 1 from the next cycle, lenExhausted is 0, and bytesDone equals 4 times the number of beats written.
- R4: Lengths are multiples of 4 bytes. When a written beat brings the bytes written up to the programmed length and that beat has sLast=0, the transfer ends with lenExhausted=1 and bytesDone equal to the length. If that beat has sLast=1, lenExhausted is 0.
- R5: While idle, mValid stays 0. The buffer accepts up to 4 beats, and sReady is 0 while it holds 4.
- R6: Beats held in the buffer when a transfer is armed are written first, in the order they were accepted.
- R7: Config writes of either kind while busy are ignored: the running transfer keeps its address and length.
- R8: Arming with a length of 0 sets done on the next cycle with no memory write, busy staying 0, bytesDone 0 and lenExhausted 0.
- R9: While mValid is 1 and mReady is 0, mValid stays 1 and mAddr and mData hold their values.
- R10: Arming a nonzero transfer clears done; busy and done are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Config write strobe |
| cfgSel | input | 1 | 0: destination address, 1: byte length (arms) |
| cfgWrData | input | ADDR_W | Config write value; length uses the low LEN_W bits |
| sValid | input | 1 | Stream beat valid |
| sReady | output | 1 | Stream beat accepted when high with sValid |
| sData | input | DATA_W | Stream beat data |
| sLast | input | 1 | End-of-packet marker |
| mValid | output | 1 | Memory write request |
| mReady | input | 1 | Memory write accepted |
| mAddr | output | ADDR_W | Memory byte address of the write |
| mData | output | DATA_W | Memory write data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Last armed transfer has completed |
| lenExhausted | output | 1 | Last transfer ended on length, not on the marker |
| bytesDone | output | LEN_W | Bytes written by the last completed transfer |

## Verification
Directed cases cover each way a transfer can end: a packet shorter than the length, which separates marker completion from length completion; a length that runs out mid-packet, which shows that leftover beats stay buffered and are written in order after re-arming; the tie where the marker falls on the length-filling beat; and zero-length arming. Beats offered while idle show whether the buffer stops at four entries with ready low, and config writes issued during a stalled transfer show whether address or length are wrongly replaced. Randomised runs then mix packet sizes, lengths, stream gaps and memory backpressure, and a bench model of accepted beats predicts every address, data word, byte count and exhaustion flag.

// File: rtl/s2m_pkg.sv
package s2m_pkg;

  typedef struct packed {
    logic addrLoad;
    logic armLoad;
    logic zeroDone;
    logic beatWrite;
    logic finish;
  } s2mStrobe_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } s2mState_t;

endpackage

// File: rtl/s2m_skid_fifo.sv
module s2m_skid_fifo #(
  parameter int WIDTH = 33,
  parameter int DEPTH = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushEn,
  input  logic [WIDTH-1:0] pushData,
  input  logic             popEn,
  output logic [WIDTH-1:0] popData,
  output logic             empty,
  output logic             full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [WIDTH-1:0] store [DEPTH];
  logic [PTR_W-1:0] wrPtr;
  logic [PTR_W-1:0] rdPtr;
  logic [CNT_W-1:0] fillCnt;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    if (p == PTR_W'(DEPTH - 1)) return '0;
    return p + 1'b1;
  endfunction

  assign empty   = (fillCnt == '0);
  assign full    = (fillCnt == CNT_W'(DEPTH));
  assign popData = store[rdPtr];

  always_ff @(posedge clk) begin
    if (pushEn && !full) store[wrPtr] <= pushData;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr   <= '0;
      rdPtr   <= '0;
      fillCnt <= '0;
    end else begin
      if (pushEn && !full) wrPtr <= nextPtr(wrPtr);
      if (popEn && !empty) rdPtr <= nextPtr(rdPtr);
      case ({pushEn && !full, popEn && !empty})
        2'b10:   fillCnt <= fillCnt + 1'b1;
        2'b01:   fillCnt <= fillCnt - 1'b1;
        default: fillCnt <= fillCnt;
      endcase
    end
  end

  // R6
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rstN)
    popEn |-> !empty);

endmodule

// File: rtl/s2m_datapath.sv
module s2m_datapath
  import s2m_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  s2mStrobe_t        strb,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              sValid,
  input  logic [DATA_W-1:0] sData,
  input  logic              sLast,
  output logic              sReady,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mData,
  output logic              headLast,
  output logic              fifoEmpty,
  output logic              lenLastBeat,
  output logic              cfgLenZero,
  output logic [LEN_W-1:0]  bytesDone
);

  localparam int BPB    = DATA_W / 8;
  localparam int ENTRY_W = DATA_W + 1;

  logic [ADDR_W-1:0]  dstAddr;
  logic [ADDR_W-1:0]  curAddr;
  logic [LEN_W-1:0]   remain;
  logic [LEN_W-1:0]   runBytes;
  logic               fifoFull;
  logic [ENTRY_W-1:0] headEntry;

  s2m_skid_fifo #(.WIDTH(ENTRY_W), .DEPTH(FIFO_DEPTH)) skid_i (
    .clk      (clk),
    .rstN     (rstN),
    .pushEn   (sValid),
    .pushData ({sLast, sData}),
    .popEn    (strb.beatWrite),
    .popData  (headEntry),
    .empty    (fifoEmpty),
    .full     (fifoFull)
  );

  assign sReady      = !fifoFull;
  assign headLast    = headEntry[DATA_W];
  assign mData       = headEntry[DATA_W-1:0];
  assign mAddr       = curAddr;
  assign lenLastBeat = (remain <= LEN_W'(BPB));
  assign cfgLenZero  = (cfgWrData[LEN_W-1:0] == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dstAddr   <= '0;
      curAddr   <= '0;
      remain    <= '0;
      runBytes  <= '0;
      bytesDone <= '0;
    end else begin
      if (strb.addrLoad) dstAddr <= cfgWrData;
      if (strb.armLoad) begin
        curAddr  <= dstAddr;
        remain   <= cfgWrData[LEN_W-1:0];
        runBytes <= '0;
      end
      if (strb.beatWrite) begin
        curAddr  <= curAddr + ADDR_W'(BPB);
        remain   <= remain - LEN_W'(BPB);
        runBytes <= runBytes + LEN_W'(BPB);
      end
      if (strb.zeroDone) bytesDone <= '0;
      if (strb.finish)   bytesDone <= runBytes + LEN_W'(BPB);
    end
  end

  // R2
  addr_stride_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.beatWrite && !strb.finish |=> mAddr == $past(mAddr) + ADDR_W'(BPB));

endmodule

// File: rtl/s2m_control.sv
module s2m_control
  import s2m_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic       cfgSel,
  input  logic       cfgLenZero,
  input  logic       fifoEmpty,
  input  logic       headLast,
  input  logic       lenLastBeat,
  input  logic       mReady,
  output s2mStrobe_t strb,
  output logic       mValid,
  output logic       busy,
  output logic       done,
  output logic       lenExhausted
);

  s2mState_t state;
  logic      idle;
  logic      armReq;
  logic      fire;

  assign idle   = (state == ST_IDLE);
  assign busy   = (state == ST_RUN);
  assign mValid = busy && !fifoEmpty;
  assign fire   = mValid && mReady;
  assign armReq = cfgWrEn && cfgSel && idle;

  always_comb begin
    strb           = '0;
    strb.addrLoad  = cfgWrEn && !cfgSel && idle;
    strb.armLoad   = armReq && !cfgLenZero;
    strb.zeroDone  = armReq && cfgLenZero;
    strb.beatWrite = fire;
    strb.finish    = fire && (headLast || lenLastBeat);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state        <= ST_IDLE;
      done         <= 1'b0;
      lenExhausted <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (strb.armLoad) begin
            state        <= ST_RUN;
            done         <= 1'b0;
            lenExhausted <= 1'b0;
          end else if (strb.zeroDone) begin
            done         <= 1'b1;
            lenExhausted <= 1'b0;
          end
        end
        ST_RUN: begin
          if (strb.finish) begin
            state        <= ST_IDLE;
            done         <= 1'b1;
            lenExhausted <= !headLast;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R3
  end_on_last_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire && headLast |=> !busy && done && !lenExhausted);

  // R4
  end_on_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    fire && lenLastBeat && !headLast |=> !busy && done && lenExhausted);

  // R8
  zero_arm_chk: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && cfgSel && cfgLenZero && !busy |=> done && !busy);

  // R10
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

endmodule

// File: rtl/s2m_oneshot_writer.sv
module s2m_oneshot_writer
  import s2m_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 16,
  parameter int FIFO_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic              cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              sValid,
  output logic              sReady,
  input  logic [DATA_W-1:0] sData,
  input  logic              sLast,
  output logic              mValid,
  input  logic              mReady,
  output logic [ADDR_W-1:0] mAddr,
  output logic [DATA_W-1:0] mData,
  output logic              busy,
  output logic              done,
  output logic              lenExhausted,
  output logic [LEN_W-1:0]  bytesDone
);

  s2mStrobe_t strb;
  logic       headLast;
  logic       fifoEmpty;
  logic       lenLastBeat;
  logic       cfgLenZero;

  s2m_control ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgSel       (cfgSel),
    .cfgLenZero   (cfgLenZero),
    .fifoEmpty    (fifoEmpty),
    .headLast     (headLast),
    .lenLastBeat  (lenLastBeat),
    .mReady       (mReady),
    .strb         (strb),
    .mValid       (mValid),
    .busy         (busy),
    .done         (done),
    .lenExhausted (lenExhausted)
  );

  s2m_datapath #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .LEN_W      (LEN_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgWrData   (cfgWrData),
    .sValid      (sValid),
    .sData       (sData),
    .sLast       (sLast),
    .sReady      (sReady),
    .mAddr       (mAddr),
    .mData       (mData),
    .headLast    (headLast),
    .fifoEmpty   (fifoEmpty),
    .lenLastBeat (lenLastBeat),
    .cfgLenZero  (cfgLenZero),
    .bytesDone   (bytesDone)
  );

  // R9
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    mValid && !mReady |=> mValid && $stable(mAddr) && $stable(mData));

endmodule

// File: tb/s2m_oneshot_writer_tb.sv
`timescale 1ns/1ps
module s2m_oneshot_writer_tb_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic        cfgSel = 1'b0;
  logic [31:0] cfgWrData = '0;
  logic        sValid = 1'b0;
  logic        sReady;
  logic [31:0] sData = '0;
  logic        sLast = 1'b0;
  logic        mValid;
  logic        mReady = 1'b0;
  logic [31:0] mAddr;
  logic [31:0] mData;
  logic        busy;
  logic        done;
  logic        lenExhausted;
  logic [15:0] bytesDone;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sPct = 100;
  int mPct = 100;

  logic [32:0] sendQ[$];
  logic [32:0] accQ[$];
  logic [63:0] wrQ[$];

  always #10 clk = ~clk;

  s2m_oneshot_writer dut_i (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgSel(cfgSel),
    .cfgWrData(cfgWrData), .sValid(sValid), .sReady(sReady), .sData(sData),
    .sLast(sLast), .mValid(mValid), .mReady(mReady), .mAddr(mAddr),
    .mData(mData), .busy(busy), .done(done), .lenExhausted(lenExhausted),
    .bytesDone(bytesDone)
  );

  // Monitor: records every accepted stream beat and every memory write.
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (sValid && sReady) accQ.push_back({sLast, sData});
      if (mValid && mReady) wrQ.push_back({mAddr, mData});
    end
  end

  // Stream source driver.
  initial begin
    bit take = 0;
    forever begin
      @(negedge clk);
      if (take) void'(sendQ.pop_front());
      take = 0;
      if (rstN && sendQ.size() > 0 && int'($urandom % 100) < sPct) begin
        sValid = 1'b1;
        {sLast, sData} = sendQ[0];
        take = sReady;
      end else begin
        sValid = 1'b0;
      end
    end
  end

  // Memory ready driver.
  initial begin
    forever begin
      @(negedge clk);
      mReady = (int'($urandom % 100) < mPct);
    end
  end

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input bit sel, input logic [31:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgSel = sel; cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic pushPacket(input int n, input bit withLast);
    for (int i = 0; i < n; i++)
      sendQ.push_back({withLast && (i == n - 1), $urandom});
  endtask

  task automatic waitDone(input string req);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk(req, "done reached", done, 1);
  endtask

  // Bench model: consume accepted beats until marker or length, compare writes.
  task automatic checkTransfer(input string req, input logic [31:0] addr,
                               input int len);
    int nb = 0;
    int bytes = 0;
    bit exh = 0;
    logic [32:0] b;
    logic [63:0] w;
    if (len > 0) begin
      forever begin
        if (accQ.size() == 0) begin
          chk(req, "beat available", 0, 1);
          break;
        end
        b = accQ.pop_front();
        if (wrQ.size() == 0) begin
          chk(req, "write present", 0, 1);
          break;
        end
        w = wrQ.pop_front();
        chk(req, "write addr", w[63:32], addr + 32'(4 * nb));
        chk(req, "write data", w[31:0], b[31:0]);
        nb++;
        bytes += 4;
        if (b[32]) break;
        if (bytes >= len) begin
          exh = 1;
          break;
        end
      end
    end
    chk(req, "no extra writes", wrQ.size(), 0);
    chk(req, "bytesDone", bytesDone, bytes);
    chk(req, "lenExhausted", lenExhausted, exh);
    chk(req, "busy low", busy, 0);
  endtask

  // Watchdog.
  always @(posedge clk) begin
    if (cyc == 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] hAddr;
    logic [31:0] hData;
    void'($urandom(32'd2024));
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "busy", busy, 0);
    chk("R1", "done", done, 0);
    chk("R1", "lenExhausted", lenExhausted, 0);
    chk("R1", "bytesDone", bytesDone, 0);
    chk("R1", "mValid", mValid, 0);
    chk("R1", "sReady", sReady, 1);

    // R8 zero-length arm
    cfgWrite(0, 32'h100);
    cfgWrite(1, 0);
    chk("R8", "done", done, 1);
    chk("R8", "busy", busy, 0);
    chk("R8", "bytesDone", bytesDone, 0);
    chk("R8", "lenExhausted", lenExhausted, 0);
    repeat (3) @(negedge clk);
    chk("R8", "no writes", wrQ.size(), 0);

    // R5 buffer fills while idle, ready drops, nothing written
    pushPacket(6, 0);
    repeat (20) @(negedge clk);
    chk("R5", "accepted while idle", accQ.size(), 4);
    chk("R5", "sReady low when full", sReady, 0);
    chk("R5", "no write while idle", wrQ.size(), 0);
    chk("R5", "mValid idle", mValid, 0);

    // R6 buffered beats written in order after arming; R4 tie case (marker on 10th beat, 40 bytes)
    pushPacket(4, 1);
    cfgWrite(0, 32'h2000);
    cfgWrite(1, 40);
    waitDone("R6");
    checkTransfer("R6", 32'h2000, 40);
    chk("R4", "tie marker wins", lenExhausted, 0);
    chk("R4", "tie bytes", bytesDone, 40);

    // R3 marker before length
    pushPacket(3, 1);
    cfgWrite(0, 32'h3000);
    cfgWrite(1, 256);
    waitDone("R3");
    checkTransfer("R3", 32'h3000, 256);
    chk("R3", "short packet bytes", bytesDone, 12);

    // R4 length runs out mid-packet
    pushPacket(5, 0);
    cfgWrite(0, 32'h4000);
    cfgWrite(1, 8);
    waitDone("R4");
    checkTransfer("R4", 32'h4000, 8);
    chk("R4", "exhausted flag", lenExhausted, 1);
    repeat (10) @(negedge clk);
    chk("R5", "no write after completion", wrQ.size(), 0);
    pushPacket(1, 1);
    cfgWrite(0, 32'h5000);
    cfgWrite(1, 100);
    waitDone("R6");
    checkTransfer("R6", 32'h5000, 100);

    // R7 / R9 / R10 under stalled memory
    mPct = 0;
    pushPacket(5, 1);
    cfgWrite(0, 32'h6000);
    cfgWrite(1, 400);
    chk("R10", "busy after arm", busy, 1);
    chk("R10", "done cleared", done, 0);
    repeat (6) @(negedge clk);
    hAddr = mAddr;
    hData = mData;
    chk("R9", "mValid held", mValid, 1);
    repeat (3) @(negedge clk);
    chk("R9", "mValid still", mValid, 1);
    chk("R9", "mAddr stable", mAddr, hAddr);
    chk("R9", "mData stable", mData, hData);
    cfgWrite(0, 32'h7000);
    cfgWrite(1, 4);
    chk("R7", "busy kept", busy, 1);
    chk("R7", "mAddr kept", mAddr, 32'h6000);
    mPct = 100;
    waitDone("R7");
    checkTransfer("R7", 32'h6000, 400);

    // Random mix (R2 main function, R8 zero arms)
    for (int t = 0; t < 40; t++) begin
      int len;
      logic [31:0] a;
      mPct = 30 + int'($urandom % 71);
      sPct = 30 + int'($urandom % 71);
      pushPacket(1 + int'($urandom % 12), 1);
      len = (($urandom % 8) == 0) ? 0 : 4 * (1 + int'($urandom % 16));
      a = $urandom & 32'hFFFF_FFFC;
      cfgWrite(0, a);
      cfgWrite(1, 32'(len));
      if (len == 0) begin
        chk("R8", "random zero arm done", done, 1);
      end else begin
        waitDone("R2");
      end
      checkTransfer("R2", a, len);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule